// File: doc/BRIEF.md
# Adaptive Critical Word Rotator

This block sits between a last-level cache and a split main memory that has a small low-latency part and a larger low-power part. Each cache line of eight words is stored with one word in the fast part and the other seven in the slow part. Which word is fast is not fixed. A 3-bit position tag, kept with the line both in the cache and in memory, records the word's position in the line. Because the fast part answers sooner, the word a processor waits for can be returned early whichever word it is.

On a dirty eviction the cache hands over the line and its cache-side tag. The block treats that tag as the prediction for the next fetch and moves the predicted word into the fast slot. It packs the remaining seven words into the slow slots in rising position order and emits the tag to be stored alongside them. A clean eviction leaves memory untouched, so no write is issued.

On a fill the block takes the two fragments and the tag stored in memory and rebuilds the line in natural word order. It also hands the cache a new tag equal to the position of the word whose request caused the miss. That word becomes the prediction used at the next dirty eviction. A line that has never been rearranged carries tag 0, so it matches the fixed layout with word 0 fast. Both directions are pure permutations followed by one register stage.

Top module: `cwr_rotator`

## Requirements
- R1: After synchronous reset, both `mem_wr_valid` and `line_valid` are low.
- R2: A writeback offered with `wb_dirty` high produces, exactly one cycle later, `mem_wr_valid` high, `mem_wr_tag` equal to `wb_tag`, and `mem_wr_fast` equal to the line word at position `wb_tag`. Word k of a line occupies bits [k*WORD_W +: WORD_W].
- R3: In that write, the slow slots hold the seven words other than position `wb_tag`, in rising position order. Slot s occupies bits [s*WORD_W +: WORD_W] of `mem_wr_slow`.
- R4: A writeback offered with `wb_dirty` low issues no memory write: `mem_wr_valid` stays low in the following cycle.
- R5: A fill produces, exactly one cycle later, `line_valid` high with the word at position `fill_tag` of `line_data` equal to `fill_fast`.
- R6: In that fill, the positions other than `fill_tag` receive the slow slots in rising order, slot 0 going to the lowest remaining position.
- R7: The fill result carries `line_tag` equal to `fill_miss_idx`, the position of the word that caused the miss.
- R8: With tag 0 the layout is the fixed split: word 0 is fast, and words 1 to 7 sit in slow slots 0 to 6, on both the writeback and the fill path.
- R9: Each accepted operation yields a single-cycle valid pulse. Operations on consecutive cycles each produce their own result, and an idle cycle gives a low valid one cycle later.
- R10: The writeback and fill paths are independent. Operations offered on both in the same cycle both complete with correct results.
- R11: Splitting a line with any tag and filling it back with the same tag returns the original line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | Eviction offered this cycle |
| wb_dirty | input | 1 | Evicted line is modified |
| wb_tag | input | TAG_W | Predicted critical position (cache-side tag) |
| wb_line | input | WORDS*WORD_W | Evicted line in natural order |
| mem_wr_valid | output | 1 | Memory write issued |
| mem_wr_tag | output | TAG_W | Tag to store with the line in memory |
| mem_wr_fast | output | WORD_W | Word for the low-latency part |
| mem_wr_slow | output | (WORDS-1)*WORD_W | Packed words for the low-power part |
| fill_valid | input | 1 | Fill fragments offered this cycle |
| fill_tag | input | TAG_W | Tag read from memory |
| fill_fast | input | WORD_W | Word from the low-latency part |
| fill_slow | input | (WORDS-1)*WORD_W | Packed words from the low-power part |
| fill_miss_idx | input | TAG_W | Position of the word that caused the miss |
| line_valid | output | 1 | Rebuilt line available |
| line_data | output | WORDS*WORD_W | Line in natural order |
| line_tag | output | TAG_W | Updated cache-side tag |

## Verification
The bench builds the block with WORDS=8 and WORD_W=16, which gives the full three-bit tag range and a 128-bit line. Every word carries a distinct value, so any misplaced slot or word position shows up directly in a comparison. Under this setting every tag from 0 to 7 can be swept through a writeback followed by a refill. That sweep covers both edge positions, where the slow packing has no gap at one end, as well as all the interior gaps.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    // Default geometry of a cache line.
    localparam int unsigned CWR_WORDS_DEF  = 8;
    localparam int unsigned CWR_WORD_W_DEF = 64;

    // Kind of an operation leaving the registered stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SPLIT = 2'd1,
        OP_JOIN  = 2'd2
    } cwr_op_e;

    // Source position for a slow slot when position fast_idx is removed.
    function automatic int unsigned slow_src(int unsigned slot, int unsigned fast_idx);
        return (slot < fast_idx) ? slot : slot + 1;
    endfunction

endpackage

// File: rtl/cwr_scatter.sv
module cwr_scatter #(
    parameter int unsigned WORDS  = cwr_pkg::CWR_WORDS_DEF,
    parameter int unsigned WORD_W = cwr_pkg::CWR_WORD_W_DEF,
    localparam int unsigned TAG_W  = $clog2(WORDS),
    localparam int unsigned LINE_W = WORDS * WORD_W,
    localparam int unsigned SLOW_W = (WORDS - 1) * WORD_W
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [WORD_W-1:0] fast_o,
    output logic [SLOW_W-1:0] slow_o
);

    // Fast word: the predicted critical position.
    assign fast_o = line_i[32'(tag_i) * WORD_W +: WORD_W];

    // Each slow slot picks its position, skipping over the fast one.
    for (genvar s = 0; s < int'(WORDS) - 1; s++) begin : g_slot
        assign slow_o[s * WORD_W +: WORD_W] =
            line_i[cwr_pkg::slow_src(s, 32'(tag_i)) * WORD_W +: WORD_W];
    end

endmodule

// File: rtl/cwr_gather.sv
module cwr_gather #(
    parameter int unsigned WORDS  = cwr_pkg::CWR_WORDS_DEF,
    parameter int unsigned WORD_W = cwr_pkg::CWR_WORD_W_DEF,
    localparam int unsigned TAG_W  = $clog2(WORDS),
    localparam int unsigned LINE_W = WORDS * WORD_W,
    localparam int unsigned SLOW_W = (WORDS - 1) * WORD_W
) (
    input  logic [WORD_W-1:0] fast_i,
    input  logic [SLOW_W-1:0] slow_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [LINE_W-1:0] line_o
);

    // Position p takes the fast word, the slot with its own index (below
    // the fast position) or the slot one lower (above it).
    for (genvar p = 0; p < int'(WORDS); p++) begin : g_pos
        if (p == 0) begin : g_first
            assign line_o[p * WORD_W +: WORD_W] =
                (tag_i == TAG_W'(p)) ? fast_i : slow_i[0 +: WORD_W];
        end else if (p == int'(WORDS) - 1) begin : g_last
            assign line_o[p * WORD_W +: WORD_W] =
                (tag_i == TAG_W'(p)) ? fast_i : slow_i[(p - 1) * WORD_W +: WORD_W];
        end else begin : g_mid
            assign line_o[p * WORD_W +: WORD_W] =
                (tag_i == TAG_W'(p)) ? fast_i :
                (TAG_W'(p) < tag_i)  ? slow_i[p * WORD_W +: WORD_W] :
                                       slow_i[(p - 1) * WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/cwr_rotator.sv
module cwr_rotator #(
    parameter int unsigned WORDS  = cwr_pkg::CWR_WORDS_DEF,
    parameter int unsigned WORD_W = cwr_pkg::CWR_WORD_W_DEF,
    localparam int unsigned TAG_W  = $clog2(WORDS),
    localparam int unsigned LINE_W = WORDS * WORD_W,
    localparam int unsigned SLOW_W = (WORDS - 1) * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_valid,
    input  logic              wb_dirty,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [LINE_W-1:0] wb_line,
    output logic              mem_wr_valid,
    output logic [TAG_W-1:0]  mem_wr_tag,
    output logic [WORD_W-1:0] mem_wr_fast,
    output logic [SLOW_W-1:0] mem_wr_slow,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_fast,
    input  logic [SLOW_W-1:0] fill_slow,
    input  logic [TAG_W-1:0]  fill_miss_idx,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_data,
    output logic [TAG_W-1:0]  line_tag
);
    import cwr_pkg::*;

    logic [WORD_W-1:0] split_fast;
    logic [SLOW_W-1:0] split_slow;
    logic [LINE_W-1:0] join_line;
    logic              split_go;
    cwr_op_e           wr_op_q;
    cwr_op_e           rd_op_q;

    // Only modified lines are rewritten; clean ones keep their memory layout.
    assign split_go = wb_valid && wb_dirty;

    cwr_scatter #(.WORDS(WORDS), .WORD_W(WORD_W)) u_scatter (
        .line_i (wb_line),
        .tag_i  (wb_tag),
        .fast_o (split_fast),
        .slow_o (split_slow)
    );

    cwr_gather #(.WORDS(WORDS), .WORD_W(WORD_W)) u_gather (
        .fast_i (fill_fast),
        .slow_i (fill_slow),
        .tag_i  (fill_tag),
        .line_o (join_line)
    );

    // Writeback stage: data registers load only on a real write.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_op_q     <= OP_IDLE;
            mem_wr_tag  <= '0;
            mem_wr_fast <= '0;
            mem_wr_slow <= '0;
        end else begin
            wr_op_q <= split_go ? OP_SPLIT : OP_IDLE;
            if (split_go) begin
                mem_wr_tag  <= wb_tag;
                mem_wr_fast <= split_fast;
                mem_wr_slow <= split_slow;
            end
        end
    end

    // Fill stage: the missing position becomes the next prediction.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_op_q   <= OP_IDLE;
            line_data <= '0;
            line_tag  <= '0;
        end else begin
            rd_op_q <= fill_valid ? OP_JOIN : OP_IDLE;
            if (fill_valid) begin
                line_data <= join_line;
                line_tag  <= fill_miss_idx;
            end
        end
    end

    assign mem_wr_valid = (wr_op_q == OP_SPLIT);
    assign line_valid   = (rd_op_q == OP_JOIN);

    // R2
    dirty_write_chk: assert property (@(posedge clk) disable iff (rst)
        split_go |=> mem_wr_valid && mem_wr_tag == $past(wb_tag));

    // R2
    fast_word_chk: assert property (@(posedge clk) disable iff (rst)
        split_go |=> mem_wr_fast == $past(wb_line[32'(wb_tag) * WORD_W +: WORD_W]));

    // R4
    clean_skip_chk: assert property (@(posedge clk) disable iff (rst)
        !split_go |=> !mem_wr_valid);

    // R7
    miss_tag_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> line_valid && line_tag == $past(fill_miss_idx));

    // R5
    fill_fast_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> line_data[32'($past(fill_tag)) * WORD_W +: WORD_W] == $past(fill_fast));

    // R9
    fill_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_valid |=> !line_valid);

endmodule

// File: tb/cwr_rotator_tb.sv
module cwr_rotator_tb;
    localparam int W  = 16;
    localparam int N  = 8;
    localparam int TW = 3;
    localparam int LW = N * W;
    localparam int SW = (N - 1) * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wb_valid = 1'b0, wb_dirty = 1'b0;
    logic [TW-1:0] wb_tag = '0;
    logic [LW-1:0] wb_line = '0;
    logic          mem_wr_valid;
    logic [TW-1:0] mem_wr_tag;
    logic [W-1:0]  mem_wr_fast;
    logic [SW-1:0] mem_wr_slow;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_tag = '0, fill_miss_idx = '0;
    logic [W-1:0]  fill_fast = '0;
    logic [SW-1:0] fill_slow = '0;
    logic          line_valid;
    logic [LW-1:0] line_data;
    logic [TW-1:0] line_tag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cwr_rotator #(.WORDS(N), .WORD_W(W)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] make_line(input int seed);
        logic [LW-1:0] l;
        for (int i = 0; i < N; i++) l[i*W +: W] = {8'(seed), 8'(i * 17 + 1)};
        return l;
    endfunction

    // Expected slow packing: walk the line, skipping the fast position.
    function automatic logic [SW-1:0] exp_slow(input logic [LW-1:0] l, input int t);
        logic [SW-1:0] s;
        int k = 0;
        for (int i = 0; i < N; i++) if (i != t) begin s[k*W +: W] = l[i*W +: W]; k++; end
        return s;
    endfunction

    // Expected rebuild: the fast word at t, slots dealt out in order elsewhere.
    function automatic logic [LW-1:0] exp_line(input logic [W-1:0] f, input logic [SW-1:0] s, input int t);
        logic [LW-1:0] l;
        int k = 0;
        for (int i = 0; i < N; i++) if (i == t) l[i*W +: W] = f; else begin l[i*W +: W] = s[k*W +: W]; k++; end
        return l;
    endfunction

    task automatic do_wb(input bit dirty, input int t, input logic [LW-1:0] l);
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = dirty; wb_tag = TW'(t); wb_line = l;
        @(posedge clk); #2;
        @(negedge clk);
        wb_valid = 1'b0; wb_dirty = 1'b0;
    endtask

    task automatic check_wb(input int t, input logic [LW-1:0] l, input string req);
        chk(mem_wr_valid === 1'b1, {req, " valid"}, LW'(mem_wr_valid), 1);
        chk(mem_wr_tag === TW'(t), {req, " tag"}, LW'(mem_wr_tag), LW'(t));
        chk(mem_wr_fast === l[t*W +: W], {req, " fast"}, LW'(mem_wr_fast), LW'(l[t*W +: W]));
        chk(mem_wr_slow === exp_slow(l, t), {req, " slow"}, LW'(mem_wr_slow), LW'(exp_slow(l, t)));
    endtask

    task automatic t_reset();
        // R1
        chk(mem_wr_valid === 1'b0, "R1 mem_wr_valid", LW'(mem_wr_valid), 0);
        chk(line_valid === 1'b0, "R1 line_valid", LW'(line_valid), 0);
    endtask

    task automatic t_dirty(input int t, input int seed);
        logic [LW-1:0] l = make_line(seed);
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = 1'b1; wb_tag = TW'(t); wb_line = l;
        @(posedge clk); #2;
        check_wb(t, l, "R2 R3");
        @(negedge clk);
        wb_valid = 1'b0; wb_dirty = 1'b0;
    endtask

    task automatic t_clean();
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = 1'b0; wb_tag = 3'd5; wb_line = make_line(9);
        @(posedge clk); #2;
        // R4
        chk(mem_wr_valid === 1'b0, "R4 clean eviction wrote", LW'(mem_wr_valid), 0);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_fill(input int t, input int miss, input int seed);
        logic [LW-1:0] src = make_line(seed);
        logic [SW-1:0] s = src[LW-1:W];
        logic [LW-1:0] e = exp_line(src[W-1:0], s, t);
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = TW'(t); fill_fast = src[W-1:0]; fill_slow = s; fill_miss_idx = TW'(miss);
        @(posedge clk); #2;
        // R5 R6
        chk(line_valid === 1'b1, "R5 valid", LW'(line_valid), 1);
        chk(line_data === e, "R5 R6 line", line_data, e);
        // R7
        chk(line_tag === TW'(miss), "R7 line_tag", LW'(line_tag), LW'(miss));
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_tag_zero();
        logic [LW-1:0] l = make_line(33);
        logic [SW-1:0] s;
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = 1'b1; wb_tag = '0; wb_line = l;
        @(posedge clk); #2;
        // R8: word 0 fast, words 1..7 in slots 0..6
        chk(mem_wr_fast === l[W-1:0], "R8 fast", LW'(mem_wr_fast), LW'(l[W-1:0]));
        chk(mem_wr_slow === l[LW-1:W], "R8 slow", LW'(mem_wr_slow), LW'(l[LW-1:W]));
        s = mem_wr_slow;
        @(negedge clk);
        wb_valid = 1'b0;
        fill_valid = 1'b1; fill_tag = '0; fill_fast = l[W-1:0]; fill_slow = s; fill_miss_idx = 3'd2;
        @(posedge clk); #2;
        chk(line_data === l, "R8 fill", line_data, l);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_back_to_back();
        logic [LW-1:0] a = make_line(51), b = make_line(52);
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = 1'b1; wb_tag = 3'd2; wb_line = a;
        @(posedge clk); #2;
        check_wb(2, a, "R9 first");
        @(negedge clk);
        wb_tag = 3'd6; wb_line = b;
        @(posedge clk); #2;
        check_wb(6, b, "R9 second");
        @(negedge clk);
        wb_valid = 1'b0; wb_dirty = 1'b0;
        @(posedge clk); #2;
        chk(mem_wr_valid === 1'b0, "R9 idle", LW'(mem_wr_valid), 0);
    endtask

    task automatic t_both();
        logic [LW-1:0] a = make_line(70), src = make_line(71);
        logic [LW-1:0] e = exp_line(src[W-1:0], src[LW-1:W], 4);
        @(negedge clk);
        wb_valid = 1'b1; wb_dirty = 1'b1; wb_tag = 3'd3; wb_line = a;
        fill_valid = 1'b1; fill_tag = 3'd4; fill_fast = src[W-1:0]; fill_slow = src[LW-1:W]; fill_miss_idx = 3'd1;
        @(posedge clk); #2;
        // R10
        check_wb(3, a, "R10 wb");
        chk(line_data === e, "R10 fill", line_data, e);
        chk(line_tag === 3'd1, "R10 tag", LW'(line_tag), 1);
        @(negedge clk);
        wb_valid = 1'b0; wb_dirty = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic t_roundtrip();
        for (int t = 0; t < N; t++) begin
            logic [LW-1:0] l = make_line(100 + t);
            logic [W-1:0]  f;
            logic [SW-1:0] s;
            logic [TW-1:0] mt;
            do_wb(1'b1, t, l);
            f = mem_wr_fast; s = mem_wr_slow; mt = mem_wr_tag;
            fill_valid = 1'b1; fill_tag = mt; fill_fast = f; fill_slow = s; fill_miss_idx = TW'((t + 3) % N);
            @(posedge clk); #2;
            // R11
            chk(line_data === l, "R11 round trip", line_data, l);
            @(negedge clk);
            fill_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dirty(0, 1);
        t_dirty(3, 2);
        t_dirty(7, 3);
        t_clean();
        t_fill(0, 4, 10);
        t_fill(5, 5, 11);
        t_fill(7, 0, 12);
        t_tag_zero();
        t_back_to_back();
        t_both();
        t_roundtrip();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule